// File: doc/BRIEF.md
# SMRAM Size Query Register

This block is one 16-bit vendor-defined register in the configuration space of a host bridge, plus the decode that turns the SMRAM control field into a byte size. Boot firmware uses it to find out whether the platform offers a larger SMRAM region than the three fixed choices. Firmware writes the all-ones query token to the register and reads it back. If an extended size has been configured, the read returns that size in megabytes. If no extended size is configured, the token comes back unchanged. Firmware can then pick the extended size through the select code that is otherwise reserved.

Writing the token first clears any stale value that earlier software left behind. Configuration space is not cleared by every kind of restart, so a plain read alone could return an old value. The extended size arrives on a static input, normally tied to 16 by the integration. When that input is zero the feature is off.

The configuration port is 32 bits wide and dword addressed, with byte enables. The register sits in the two low byte lanes of the dword at offset 0x50, which covers byte offsets 0x50 and 0x51. Reads are combinational. Writes take effect at the next rising clock edge.

Top module: `smram_size_reg`

## Requirements
- R1: After reset the register holds the configured extended size (`ext_size_mb` zero-extended to 16 bits), which is 0 when the feature is off.
- R2: A write to dword 0x50 stores `cfg_wdata[15:0]` through byte enables 0 and 1. Any value other than 0xFFFF reads back unchanged at `cfg_rdata[15:0]`. Lanes 2 and 3 of that dword always read 0.
- R3: When a write leaves both register bytes at 0xFF and `ext_size_mb` is nonzero, the register then reads back `ext_size_mb` instead of 0xFFFF.
- R4: When `ext_size_mb` is 0, a written 0xFFFF reads back as 0xFFFF.
- R5: A byte enable of 0 leaves that register byte unchanged. Writing the two bytes of the token in separate accesses performs the query substitution only on the access that completes 0xFFFF.
- R6: Writes to any other dword leave the register unchanged. Reads of any other dword return 0.
- R7: `size_sel` 00, 01 and 10 give `smram_bytes` of 1 MB, 2 MB and 8 MB (0x0010_0000, 0x0020_0000, 0x0080_0000) with `smram_valid` high.
- R8: `size_sel` 11 with nonzero `ext_size_mb` gives `smram_bytes` = `ext_size_mb` << 20 with `smram_valid` high. The largest value, 0xFFF, gives 0xFFF0_0000.
- R9: `size_sel` 11 with `ext_size_mb` of 0 drives `smram_valid` low and `smram_bytes` to 0.
- R10: A write changes `cfg_rdata` only after the next rising clock edge. A read reflects the stored value in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 8 | Config byte address (low two bits ignored) |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 4 | Byte enables for the dword |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the addressed dword |
| ext_size_mb | input | 12 | Configured extended size in MB, 0 disables |
| size_sel | input | 2 | SMRAM size select code |
| smram_bytes | output | 32 | Effective SMRAM size in bytes |
| smram_valid | output | 1 | Low when the reserved code is selected |

## Verification
A corrupted stored value shows up on `cfg_rdata` at the first read of dword 0x50 after the edge that wrote it. A missed or misplaced token substitution therefore appears one cycle after the completing write, either as 0xFFFF where the size was expected or the reverse. A wrong byte lane shows as the neighbouring byte changing on a partial write. The size decode has no state, so a wrong code mapping or a wrong valid flag appears in the same cycle that `size_sel` changes.

// File: rtl/smram_q_pkg.sv
package smram_q_pkg;

    typedef enum logic [1:0] {
        SEL_1MB = 2'b00,
        SEL_2MB = 2'b01,
        SEL_8MB = 2'b10,
        SEL_EXT = 2'b11
    } size_sel_e;

    localparam int MB_SHIFT = 20;

endpackage

// File: rtl/sq_cfg_decode.sv
module sq_cfg_decode #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int REG_W      = 16,
    parameter int REG_OFFSET = 'h50
) (
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic                cfg_wr,
    input  logic [DATA_W/8-1:0] cfg_be,
    input  logic [DATA_W-1:0]   cfg_wdata,
    input  logic [REG_W-1:0]    reg_val,
    output logic [REG_W/8-1:0]  byte_we,
    output logic [REG_W-1:0]    wr_bytes,
    output logic                hit,
    output logic [DATA_W-1:0]   cfg_rdata
);
    localparam int BE_W      = DATA_W / 8;
    localparam int IDX_LSB   = $clog2(BE_W);
    localparam int REG_BYTES = REG_W / 8;
    localparam int LANE0     = REG_OFFSET % BE_W;
    localparam logic [ADDR_W-IDX_LSB-1:0] REG_DW = ADDR_W'(REG_OFFSET) >> IDX_LSB;

    assign hit = (cfg_addr[ADDR_W-1:IDX_LSB] == REG_DW);

    // Route each register byte to its lane of the dword
    for (genvar b = 0; b < REG_BYTES; b++) begin : g_lane
        assign byte_we[b]         = hit & cfg_wr & cfg_be[LANE0+b];
        assign wr_bytes[b*8 +: 8] = cfg_wdata[(LANE0+b)*8 +: 8];
    end

    always_comb begin
        cfg_rdata = '0;
        if (hit) begin
            cfg_rdata[LANE0*8 +: REG_W] = reg_val;
        end
    end

endmodule

// File: rtl/sq_qreg.sv
module sq_qreg #(
    parameter int REG_W = 16,
    parameter int EXT_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REG_W/8-1:0] byte_we,
    input  logic [REG_W-1:0]   wr_bytes,
    input  logic [EXT_W-1:0]   ext_mb,
    output logic [REG_W-1:0]   val_q
);
    localparam int REG_BYTES = REG_W / 8;

    typedef struct packed {
        logic [REG_W-1:0] val;
    } qreg_t;

    qreg_t            st_d, st_q;
    logic [REG_W-1:0] merged;
    logic [REG_W-1:0] ext_wide;
    logic             feat_on;

    assign ext_wide = {{(REG_W-EXT_W){1'b0}}, ext_mb};
    assign feat_on  = (ext_mb != '0);

    always_comb begin
        merged = st_q.val;
        for (int b = 0; b < REG_BYTES; b++) begin
            if (byte_we[b]) begin
                merged[b*8 +: 8] = wr_bytes[b*8 +: 8];
            end
        end
        st_d = st_q;
        if (|byte_we) begin
            // A completed query token is replaced by the configured size
            st_d.val = (feat_on && (merged == '1)) ? ext_wide : merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.val <= ext_wide;
        end else begin
            st_q <= st_d;
        end
    end

    assign val_q = st_q.val;

    AST_RESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (val_q == ext_wide)); // R1

    AST_TOKEN_SUBST: assert property (@(posedge clk) disable iff (!rst_n)
        ((&byte_we) && (wr_bytes == '1) && feat_on) |=> (val_q == $past(ext_wide))); // R3

    AST_TOKEN_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        ((&byte_we) && (wr_bytes == '1) && !feat_on) |=> (val_q == '1)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we == '0) |=> $stable(val_q)); // R10

    for (genvar b = 0; b < REG_BYTES; b++) begin : g_keep
        AST_LANE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (!byte_we[b] && !feat_on) |=> (val_q[b*8 +: 8] == $past(val_q[b*8 +: 8]))); // R5
    end

endmodule

// File: rtl/sq_size_dec.sv
module sq_size_dec
    import smram_q_pkg::*;
#(
    parameter int EXT_W   = 12,
    parameter int BYTES_W = EXT_W + MB_SHIFT
) (
    input  logic [1:0]         size_sel,
    input  logic [EXT_W-1:0]   ext_mb,
    output logic [BYTES_W-1:0] smram_bytes,
    output logic               smram_valid
);
    logic [EXT_W-1:0] mb;
    size_sel_e        sel;

    assign sel = size_sel_e'(size_sel);

    always_comb begin
        smram_valid = 1'b1;
        unique case (sel)
            SEL_1MB: mb = EXT_W'(1);
            SEL_2MB: mb = EXT_W'(2);
            SEL_8MB: mb = EXT_W'(8);
            SEL_EXT: begin
                mb          = ext_mb;
                smram_valid = (ext_mb != '0);
            end
            default: mb = '0;
        endcase
        smram_bytes = {{(BYTES_W-EXT_W){1'b0}}, mb} << MB_SHIFT;
    end

endmodule

// File: rtl/smram_size_reg.sv
module smram_size_reg
    import smram_q_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int REG_W      = 16,
    parameter int EXT_W      = 12,
    parameter int REG_OFFSET = 'h50
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         cfg_addr,
    input  logic                      cfg_wr,
    input  logic [DATA_W/8-1:0]       cfg_be,
    input  logic [DATA_W-1:0]         cfg_wdata,
    output logic [DATA_W-1:0]         cfg_rdata,
    input  logic [EXT_W-1:0]          ext_size_mb,
    input  logic [1:0]                size_sel,
    output logic [EXT_W+MB_SHIFT-1:0] smram_bytes,
    output logic                      smram_valid
);
    localparam int REG_BYTES = REG_W / 8;

    logic [REG_BYTES-1:0] byte_we;
    logic [REG_W-1:0]     wr_bytes;
    logic [REG_W-1:0]     reg_val;
    logic                 hit;

    sq_cfg_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W), .REG_OFFSET(REG_OFFSET)
    ) u_dec (
        .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .reg_val(reg_val), .byte_we(byte_we), .wr_bytes(wr_bytes), .hit(hit),
        .cfg_rdata(cfg_rdata)
    );

    sq_qreg #(.REG_W(REG_W), .EXT_W(EXT_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .byte_we(byte_we), .wr_bytes(wr_bytes),
        .ext_mb(ext_size_mb), .val_q(reg_val)
    );

    sq_size_dec #(.EXT_W(EXT_W)) u_size (
        .size_sel(size_sel), .ext_mb(ext_size_mb),
        .smram_bytes(smram_bytes), .smram_valid(smram_valid)
    );

    AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (cfg_rdata == '0)); // R6

    AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !hit) |=> $stable(reg_val)); // R6

    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !smram_valid |-> (smram_bytes == '0 && size_sel == 2'b11)); // R9

    AST_VALID_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        smram_valid |-> (smram_bytes[MB_SHIFT-1:0] == '0 && smram_bytes != '0)); // R7

endmodule

// File: tb/smram_size_reg_test.sv
module smram_size_reg_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_addr = 8'h50;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [11:0] ext_size_mb = 12'd16;
    logic [1:0]  size_sel = 2'b00;
    logic [31:0] smram_bytes;
    logic        smram_valid;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    smram_size_reg uut (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ext_size_mb(ext_size_mb), .size_sel(size_sel),
        .smram_bytes(smram_bytes), .smram_valid(smram_valid)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [3:0]  be;
        logic [31:0] wd;
        logic [1:0]  sel;
        logic [31:0] exp_rd;
        logic [31:0] exp_bytes;
        logic        exp_v;
        logic [23:0] tag;
    } vec_t;

    // Walked with ext_size_mb = 16 after reset
    localparam vec_t VECS [10] = '{
        '{1'b0, 8'h50, 4'h0, 32'h0,         2'b00, 32'h0000_0010, 32'h0010_0000, 1'b1, "R1 "},
        '{1'b1, 8'h50, 4'h3, 32'h0000_1234, 2'b01, 32'h0000_1234, 32'h0020_0000, 1'b1, "R2 "},
        '{1'b1, 8'h50, 4'h1, 32'h0000_00FF, 2'b10, 32'h0000_12FF, 32'h0080_0000, 1'b1, "R5 "},
        '{1'b1, 8'h50, 4'h2, 32'h0000_FF00, 2'b11, 32'h0000_0010, 32'h0100_0000, 1'b1, "R3 "},
        '{1'b1, 8'h54, 4'hF, 32'hFFFF_FFFF, 2'b00, 32'h0000_0000, 32'h0010_0000, 1'b1, "R6 "},
        '{1'b0, 8'h50, 4'h0, 32'h0,         2'b11, 32'h0000_0010, 32'h0100_0000, 1'b1, "R6 "},
        '{1'b1, 8'h50, 4'hF, 32'hABCD_5555, 2'b01, 32'h0000_5555, 32'h0020_0000, 1'b1, "R2 "},
        '{1'b1, 8'h50, 4'hC, 32'hFFFF_0000, 2'b10, 32'h0000_5555, 32'h0080_0000, 1'b1, "R5 "},
        '{1'b1, 8'h50, 4'h3, 32'h0000_FFFF, 2'b00, 32'h0000_0010, 32'h0010_0000, 1'b1, "R3 "},
        '{1'b1, 8'h4C, 4'hF, 32'h0000_FFFF, 2'b11, 32'h0000_0000, 32'h0100_0000, 1'b1, "R6 "}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [11:0] ext);
        @(negedge clk);
        rst_n       = 1'b0;
        cfg_wr      = 1'b0;
        ext_size_mb = ext;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One write at a negedge, checked at the following negedge
    task automatic cfg_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        cfg_addr  = a;
        cfg_be    = be;
        cfg_wdata = d;
        cfg_wr    = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset(12'd16);

        for (int i = 0; i < 10; i++) begin
            size_sel = VECS[i].sel;
            if (VECS[i].wr) begin
                cfg_write(VECS[i].addr, VECS[i].be, VECS[i].wd);
            end else begin
                cfg_addr = VECS[i].addr;
                @(negedge clk);
            end
            #1;
            check(cfg_rdata == VECS[i].exp_rd, $sformatf("%s rdata vec %0d", VECS[i].tag, i),
                  cfg_rdata, VECS[i].exp_rd);
            check(smram_bytes == VECS[i].exp_bytes && smram_valid == VECS[i].exp_v,
                  $sformatf("R7/R8 size vec %0d", i), smram_bytes, VECS[i].exp_bytes);
        end

        // R10: write not visible before the edge, visible after
        cfg_addr  = 8'h50;
        cfg_be    = 4'h3;
        cfg_wdata = 32'h0000_0A0B;
        cfg_wr    = 1'b1;
        #1;
        check(cfg_rdata == 32'h10, "R10 before edge", cfg_rdata, 32'h10);
        @(negedge clk);
        cfg_wr = 1'b0;
        #1;
        check(cfg_rdata == 32'h0A0B, "R10 after edge", cfg_rdata, 32'h0A0B);

        // Feature disabled
        do_reset(12'd0);
        cfg_addr = 8'h50;
        #1;
        check(cfg_rdata == 32'h0, "R1 reset with ext 0", cfg_rdata, 32'h0);
        size_sel = 2'b11;
        #1;
        check(smram_valid == 1'b0, "R9 valid low", {31'b0, smram_valid}, 32'h0);
        check(smram_bytes == 32'h0, "R9 bytes zero", smram_bytes, 32'h0);
        cfg_write(8'h50, 4'h3, 32'h0000_FFFF);
        #1;
        check(cfg_rdata == 32'h0000_FFFF, "R4 token kept", cfg_rdata, 32'h0000_FFFF);
        cfg_write(8'h50, 4'h2, 32'h0000_3400);
        #1;
        check(cfg_rdata == 32'h0000_34FF, "R5 high lane only", cfg_rdata, 32'h0000_34FF);
        size_sel = 2'b10;
        #1;
        check(smram_bytes == 32'h0080_0000 && smram_valid, "R7 8MB with ext 0",
              smram_bytes, 32'h0080_0000);

        // Largest extended size
        do_reset(12'hFFF);
        #1;
        check(cfg_rdata == 32'h0000_0FFF, "R1 reset with ext max", cfg_rdata, 32'h0FFF);
        size_sel = 2'b11;
        #1;
        check(smram_bytes == 32'hFFF0_0000 && smram_valid, "R8 max size",
              smram_bytes, 32'hFFF0_0000);
        cfg_write(8'h50, 4'h3, 32'h0000_0001);
        cfg_write(8'h50, 4'hF, 32'hFFFF_FFFF);
        #1;
        check(cfg_rdata == 32'h0000_0FFF, "R3 token with ext max", cfg_rdata, 32'h0FFF);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule